// File: doc/BRIEF.md
# Deferred Invalidation Queue with Read-Barrier Load Stall

This block sits beside one private cache and takes invalidation messages from the coherence interconnect for it. Each accepted invalidation is acknowledged in the next cycle. The block does not wait for the cache to act on it. The message is stored in a small in-order queue and later handed to the cache through an apply port. The cache then drives the named line to the Invalid state. Until that happens, the old copy of the line stays readable.

A read-barrier pulse tags every entry present in the queue at that moment. The core checks each load address against the queue. If the address matches a tagged entry that has not yet been applied, the stall output holds the load back. The stall lasts until that entry has been handed to the cache. By then the line is Invalid, so the released load misses and the cache fetches a fresh copy with a read request. Loads that match only untagged entries go ahead and may see the stale value.

Top module: `invq_barrier`

## Requirements
- R1: An invalidation is accepted in a cycle where `inv_valid` and `inv_ready` are both high. In the following cycle `ack_valid` is high for exactly one cycle and `ack_addr` carries the accepted address.
- R2: When DEPTH entries are queued, `inv_ready` is low. An invalidation offered while the queue is full is neither acknowledged nor queued.
- R3: An invalidation whose address equals an entry already queued is still accepted and acknowledged. It is also applied as a separate entry.
- R4: `apl_valid` is high whenever the queue holds an entry, and `apl_addr` shows the oldest entry. An entry leaves the queue on a cycle with `apl_valid` and `apl_ready` both high. At most one entry leaves per cycle, and entries leave in arrival order. While `apl_ready` is low, `apl_addr` holds steady.
- R5: A pulse on `rbar_mark` tags every entry queued before that clock edge. An invalidation accepted in the same cycle as the pulse stays untagged.
- R6: `ld_stall` is high in the same cycle when `ld_valid` is high and `ld_addr` equals the address of a tagged queued entry.
- R7: A load whose address matches only untagged entries, or no entry at all, is not stalled.
- R8: A stalled load is released in the cycle after the apply handshake of the last tagged entry that matches it. From that cycle on, the cache line is Invalid, so the load misses and refetches.
- R9: After reset the queue is empty: `inv_ready` is high, and `ack_valid`, `apl_valid` and `ld_stall` are low.
- R10: A barrier pulse on an empty queue has no lasting effect. An entry queued after it does not stall loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_valid | input | 1 | Incoming invalidation present |
| inv_addr | input | ADDR_W | Line address to invalidate |
| inv_ready | output | 1 | Queue can accept an invalidation |
| ack_valid | output | 1 | Acknowledge pulse toward the interconnect |
| ack_addr | output | ADDR_W | Address being acknowledged |
| rbar_mark | input | 1 | Read-barrier pulse that tags all queued entries |
| ld_valid | input | 1 | Load lookup present |
| ld_addr | input | ADDR_W | Load line address |
| ld_stall | output | 1 | Load must wait (combinational) |
| apl_valid | output | 1 | Oldest entry offered to the cache |
| apl_addr | output | ADDR_W | Line the cache must drive to Invalid |
| apl_ready | input | 1 | Cache takes the offered entry this cycle |

## Verification
Each result has its own due time. The acknowledge comes one clock after acceptance. The stall is combinational in the load's own cycle. The stall releases one clock after the apply handshake of the matching tagged entry. An applied entry is seen on the apply port in the cycle before the handshake edge.

Inputs change just after a rising edge and outputs are sampled at the falling edge. Each check is therefore made at the falling edge of the cycle in which its result is due. A scoreboard records every accepted invalidation twice: once as an expected acknowledge and once as an expected apply. A monitor pops these records as the matching outputs appear. Any acknowledge or apply with no record behind it counts as a failure, which catches invalidations wrongly taken while the queue is full.

// File: rtl/invq_pkg.sv
package invq_pkg;
  localparam int unsigned INVQ_ADDR_W_DEF = 16;
  localparam int unsigned INVQ_DEPTH_DEF  = 4;

  // next ring position, wrapping at depth
  function automatic int unsigned ring_next(input int unsigned cur, input int unsigned depth);
    return (cur + 1 >= depth) ? 0 : cur + 1;
  endfunction

  // a slot blocks a load when it is occupied, tagged and names the same line
  function automatic logic slot_blocks(input logic occ, input logic tag, input logic same);
    return occ & tag & same;
  endfunction
endpackage

// File: rtl/invq_store.sv
module invq_store
  import invq_pkg::*;
#(
  parameter int unsigned ADDR_W = INVQ_ADDR_W_DEF,
  parameter int unsigned DEPTH  = INVQ_DEPTH_DEF
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [ADDR_W-1:0]              push_addr,
  input  logic                           pop,
  input  logic                           mark_all,
  output logic                           full,
  output logic                           empty,
  output logic [ADDR_W-1:0]              head_addr,
  output logic [DEPTH-1:0]               slot_occ,
  output logic [DEPTH-1:0]               slot_tag,
  output logic [DEPTH-1:0][ADDR_W-1:0]   slot_addr
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0]            wr_ptr, rd_ptr;
  logic [CNT_W-1:0]            fill;
  logic [DEPTH-1:0]            occ_q, tag_q;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;

  assign full      = (fill == CNT_W'(DEPTH));
  assign empty     = (fill == '0);
  assign head_addr = addr_q[rd_ptr];
  assign slot_occ  = occ_q;
  assign slot_tag  = tag_q;
  assign slot_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      tag_q  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      // barrier tags only what was already present before this edge
      if (mark_all) tag_q <= tag_q | occ_q;
      if (push) begin
        occ_q[wr_ptr] <= 1'b1;
        tag_q[wr_ptr] <= 1'b0;
        wr_ptr        <= PTR_W'(ring_next(32'(wr_ptr), DEPTH));
      end
      if (pop) begin
        occ_q[rd_ptr] <= 1'b0;
        tag_q[rd_ptr] <= 1'b0;
        rd_ptr        <= PTR_W'(ring_next(32'(rd_ptr), DEPTH));
      end
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) addr_q[wr_ptr] <= push_addr;
  end

  // R2: the ring never takes a write while every slot is occupied
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_tag_chk
      // R5: a tag never outlives its entry
      p_tag_on_occupied_r5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tag[s] |-> slot_occ[s]);
    end
  endgenerate
endmodule

// File: rtl/invq_probe.sv
module invq_probe
  import invq_pkg::*;
#(
  parameter int unsigned ADDR_W = INVQ_ADDR_W_DEF,
  parameter int unsigned DEPTH  = INVQ_DEPTH_DEF
) (
  input  logic                         ld_valid,
  input  logic [ADDR_W-1:0]            ld_addr,
  input  logic [DEPTH-1:0]             slot_occ,
  input  logic [DEPTH-1:0]             slot_tag,
  input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
  output logic [DEPTH-1:0]             hit_vec,
  output logic                         ld_stall
);
  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
      assign hit_vec[s] = slot_blocks(slot_occ[s], slot_tag[s], slot_addr[s] == ld_addr);
    end
  endgenerate

  assign ld_stall = ld_valid & (|hit_vec);
endmodule

// File: rtl/invq_ack_reg.sv
module invq_ack_reg
  import invq_pkg::*;
#(
  parameter int unsigned ADDR_W = INVQ_ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] take_addr,
  output logic              ack_valid,
  output logic [ADDR_W-1:0] ack_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack_addr  <= '0;
    end else begin
      ack_valid <= take;
      if (take) ack_addr <= take_addr;
    end
  end
endmodule

// File: rtl/invq_barrier.sv
module invq_barrier
  import invq_pkg::*;
#(
  parameter int unsigned ADDR_W = INVQ_ADDR_W_DEF,
  parameter int unsigned DEPTH  = INVQ_DEPTH_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              inv_ready,
  output logic              ack_valid,
  output logic [ADDR_W-1:0] ack_addr,
  input  logic              rbar_mark,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_stall,
  output logic              apl_valid,
  output logic [ADDR_W-1:0] apl_addr,
  input  logic              apl_ready
);
  logic                         q_full, q_empty;
  logic [ADDR_W-1:0]            q_head;
  logic [DEPTH-1:0]             q_occ, q_tag, q_hit;
  logic [DEPTH-1:0][ADDR_W-1:0] q_addr;
  logic                         ev_accept, ev_apply;

  assign inv_ready = ~q_full;
  assign ev_accept = inv_valid & inv_ready;
  assign apl_valid = ~q_empty;
  assign apl_addr  = q_head;
  assign ev_apply  = apl_valid & apl_ready;

  invq_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_accept),
    .push_addr (inv_addr),
    .pop       (ev_apply),
    .mark_all  (rbar_mark),
    .full      (q_full),
    .empty     (q_empty),
    .head_addr (q_head),
    .slot_occ  (q_occ),
    .slot_tag  (q_tag),
    .slot_addr (q_addr)
  );

  invq_probe #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) probe_i (
    .ld_valid  (ld_valid),
    .ld_addr   (ld_addr),
    .slot_occ  (q_occ),
    .slot_tag  (q_tag),
    .slot_addr (q_addr),
    .hit_vec   (q_hit),
    .ld_stall  (ld_stall)
  );

  invq_ack_reg #(.ADDR_W(ADDR_W)) ack_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (ev_accept),
    .take_addr (inv_addr),
    .ack_valid (ack_valid),
    .ack_addr  (ack_addr)
  );

  // R1: acknowledge follows acceptance by one cycle with the same line
  p_ack_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (ack_valid && ack_addr == $past(inv_addr)));

  p_ack_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_accept |=> !ack_valid);

  // R4: offered head stays put while the cache is not ready
  p_head_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (apl_valid && !apl_ready) |=> (apl_valid && $stable(apl_addr)));

  // R6: a stall needs something queued to wait on
  p_stall_needs_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |-> !q_empty);

  // R10: a barrier on an empty queue leaves nothing tagged
  p_empty_barrier_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rbar_mark && q_empty) |=> (q_tag == '0));
endmodule

// File: tb/invq_barrier_tb_top.sv
module invq_barrier_tb_top;
  localparam int unsigned AW = 16;
  localparam int unsigned DP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inv_valid = 1'b0;
  logic [AW-1:0] inv_addr = '0;
  logic          inv_ready;
  logic          ack_valid;
  logic [AW-1:0] ack_addr;
  logic          rbar_mark = 1'b0;
  logic          ld_valid = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic          ld_stall;
  logic          apl_valid;
  logic [AW-1:0] apl_addr;
  logic          apl_ready = 1'b0;

  int errors = 0;
  int checks = 0;
  bit run    = 1'b0;
  bit done   = 1'b0;
  logic [AW-1:0] ack_q[$];
  logic [AW-1:0] apl_q[$];

  always #4 clk = ~clk;

  invq_barrier #(.ADDR_W(AW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ready(inv_ready),
    .ack_valid(ack_valid), .ack_addr(ack_addr),
    .rbar_mark(rbar_mark),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_stall(ld_stall),
    .apl_valid(apl_valid), .apl_addr(apl_addr), .apl_ready(apl_ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic next_cyc();
    @(posedge clk); #1;
  endtask

  // monitor: scoreboard pops as acknowledges and applies appear
  always @(negedge clk) begin
    if (run && rst_n) begin
      if (ack_valid) begin
        if (ack_q.size() == 0) chk(1'b0, "R1/R2", "unexpected ack", int'(ack_addr), 0);
        else begin
          logic [AW-1:0] e;
          e = ack_q.pop_front();
          chk(ack_addr == e, "R1", "ack address", int'(ack_addr), int'(e));
        end
      end
      if (apl_valid && apl_ready) begin
        if (apl_q.size() == 0) chk(1'b0, "R4", "unexpected apply", int'(apl_addr), 0);
        else begin
          logic [AW-1:0] e;
          e = apl_q.pop_front();
          chk(apl_addr == e, "R4", "apply order", int'(apl_addr), int'(e));
        end
      end
    end
  end

  // driver: one invalidation in this cycle, optionally with a barrier
  task automatic send(input logic [AW-1:0] a, input bit bar, input bit exp_rdy, input string req);
    inv_valid = 1'b1; inv_addr = a; rbar_mark = bar;
    @(negedge clk);
    chk(inv_ready == exp_rdy, req, "inv_ready", int'(inv_ready), int'(exp_rdy));
    if (inv_ready) begin
      ack_q.push_back(a);
      apl_q.push_back(a);
    end
    next_cyc();
    inv_valid = 1'b0; rbar_mark = 1'b0;
  endtask

  task automatic barrier();
    rbar_mark = 1'b1;
    next_cyc();
    rbar_mark = 1'b0;
  endtask

  task automatic load(input logic [AW-1:0] a, input bit exp, input string req);
    ld_valid = 1'b1; ld_addr = a;
    @(negedge clk);
    chk(ld_stall == exp, req, "ld_stall", int'(ld_stall), int'(exp));
    next_cyc();
    ld_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(inv_ready == 1'b1, "R9", "inv_ready", int'(inv_ready), 1);
    chk(ack_valid == 1'b0, "R9", "ack_valid", int'(ack_valid), 0);
    chk(apl_valid == 1'b0, "R9", "apl_valid", int'(apl_valid), 0);
    chk(ld_stall  == 1'b0, "R9", "ld_stall", int'(ld_stall), 0);
    run = 1'b1;
    next_cyc();

    send(16'h0010, 1'b0, 1'b1, "R1");
    send(16'h0020, 1'b0, 1'b1, "R1");
    load(16'h0010, 1'b0, "R7");                 // queued but untagged
    send(16'h0030, 1'b1, 1'b1, "R5");           // barrier in the same cycle
    load(16'h0010, 1'b1, "R6");
    load(16'h0020, 1'b1, "R6");
    load(16'h0030, 1'b0, "R5");                 // same-cycle entry stays untagged
    load(16'h0077, 1'b0, "R7");                 // no entry at all
    @(negedge clk);
    chk(apl_valid && apl_addr == 16'h0010, "R4", "head held", int'(apl_addr), 16'h0010);
    next_cyc();

    send(16'h0010, 1'b0, 1'b1, "R3");           // duplicate line, fills the queue
    for (int k = 0; k < 3; k++) send(16'h0050, 1'b0, 1'b0, "R2");
    load(16'h0010, 1'b1, "R3");

    // release sequence
    ld_valid = 1'b1; ld_addr = 16'h0010; apl_ready = 1'b1;
    @(negedge clk);
    chk(ld_stall == 1'b1, "R8", "stall before apply", int'(ld_stall), 1);
    next_cyc();
    apl_ready = 1'b0;
    @(negedge clk);
    chk(ld_stall == 1'b0, "R8", "released after apply", int'(ld_stall), 0);
    chk(inv_ready == 1'b1, "R2", "ready after apply", int'(inv_ready), 1);
    next_cyc();
    ld_addr = 16'h0020; apl_ready = 1'b1;
    @(negedge clk);
    chk(ld_stall == 1'b1, "R8", "second line stalled", int'(ld_stall), 1);
    next_cyc();
    @(negedge clk);
    chk(ld_stall == 1'b0, "R8", "second line released", int'(ld_stall), 0);
    next_cyc();
    ld_valid = 1'b0;
    repeat (4) next_cyc();
    @(negedge clk);
    chk(apl_valid == 1'b0, "R4", "drained", int'(apl_valid), 0);
    next_cyc();

    apl_ready = 1'b0;
    barrier();                                  // empty queue
    send(16'h0040, 1'b0, 1'b1, "R10");
    load(16'h0040, 1'b0, "R10");
    apl_ready = 1'b1;
    repeat (4) next_cyc();
    @(negedge clk);
    chk(ack_q.size() == 0, "R1", "acks outstanding", ack_q.size(), 0);
    chk(apl_q.size() == 0, "R4", "applies outstanding", apl_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule